// File: doc/BRIEF.md
# Packed-Pixel Frame Buffer Fetch

This block reads a byte-wide video memory that is only ever read, never written, and turns it into a stream of 2-bit pixels for the colour stage. Every byte holds four pixels. The read address comes directly from the raster counters, so no address arithmetic is needed. The low 9 bits of the line counter pick one of 512 pages. Bits [7:2] of the pixel counter pick one of the 64 bytes in that page, and 64 bytes of four pixels each make one 256-pixel line.

A byte register captures the memory data once per group of four pixel clocks. On the other three clocks it moves the next pixel pair to the top of the register. The memory controls keep the part always selected with writes off, and its outputs are turned off while the pipelined blank is active. The pixel output is forced to zero during blanking.

Top module: `pf_fetch_top`

## Requirements
- R1: `mem_addr_o` is `{line_cnt_i[8:0], pix_cnt_i[7:2]}`: the line bits are the upper 9 address bits and the pixel bits are the lower 6.
- R2: `mem_ce_no` is always 0 (the memory is selected) and `mem_we_no` is always 1 (writes are off), including during reset.
- R3: `mem_oe_no` is 1 while `blank_q_i` is 1 and 0 while it is 0.
- R4: While `rst_ni` is low, the byte register is cleared without waiting for a clock, so `pixel_o` reads 0.
- R5: On a rising clock edge with `pix_cnt_i[1:0] == 2'b11`, the byte register loads `mem_rdata_i`.
- R6: On a rising clock edge with `pix_cnt_i[1:0] != 2'b11`, the byte register shifts left by 2 bits and fills with zeros. `pixel_o` presents bits [7:6] of the register, so the pixels of a byte come out most significant pair first.
- R7: While `blank_q_i` is 1, `pixel_o` is 0 whatever the register holds.
- R8: Line counter bit 9 and pixel counter bits 9:8 and 1:0 have no effect on `mem_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_cnt_i | input | 10 | Horizontal pixel counter |
| line_cnt_i | input | 10 | Vertical line counter |
| blank_q_i | input | 1 | Pipelined blank, high while video is blanked |
| mem_rdata_i | input | 8 | Read data from video memory |
| mem_addr_o | output | 15 | Video memory byte address |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| pixel_o | output | 2 | Current pixel value |

## Verification
The bench steps through whole lines in order, so every load-and-shift phase is exercised against byte patterns in which each pixel pair differs. A design that loads on the wrong counter phase or unpacks the byte in the wrong order would show each pixel in the wrong slot. Line counts above 511 and arbitrary pixel counts check that the unused counter bits stay out of the address; a design that took the wrong slice would read from the wrong page. Blanking is switched in the middle of a byte to check two things: the forced-zero output, and that the register keeps shifting underneath so pixels resume in the right place. A design that froze the register would show the wrong pixels afterwards. A reset between clock edges must clear the output at once, which a design with a synchronous clear would not do.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned PF_DATA_W = 8;
  localparam int unsigned PF_BPP    = 2;

  typedef logic [PF_BPP-1:0] pf_pixel_t;

  // true when the low counter bits sit on the last pixel of a byte
  function automatic logic pf_is_load(input logic [$clog2(PF_DATA_W/PF_BPP)-1:0] phase);
    return &phase;
  endfunction
endpackage

// File: rtl/pf_addr_gen.sv
module pf_addr_gen #(
  parameter int unsigned PIX_W     = 10,
  parameter int unsigned LINE_W    = 10,
  parameter int unsigned PAGE_BITS = 9,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned BYTE_W    = 6,
  localparam int unsigned ADDR_W   = PAGE_BITS + BYTE_W
) (
  input  logic [PIX_W-1:0]  pix_cnt_i,
  input  logic [LINE_W-1:0] line_cnt_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [PAGE_BITS-1:0] page;
  logic [BYTE_W-1:0]    byte_idx;

  assign page     = line_cnt_i[PAGE_BITS-1:0];
  assign byte_idx = pix_cnt_i[SEL_W+BYTE_W-1:SEL_W];
  assign addr_o   = {page, byte_idx};
endmodule

// File: rtl/pf_mem_ctrl.sv
module pf_mem_ctrl #(
  parameter bit GATE_OE = 1'b1
) (
  input  logic blank_q_i,
  output logic ce_no,
  output logic we_no,
  output logic oe_no
);
  assign ce_no = 1'b0;
  assign we_no = 1'b1;

  generate
    if (GATE_OE) begin : g_gate
      assign oe_no = blank_q_i;
    end else begin : g_open
      assign oe_no = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pf_shift_reg.sv
module pf_shift_reg
  import pf_pkg::*;
#(
  parameter int unsigned DATA_W = PF_DATA_W,
  parameter int unsigned BPP    = PF_BPP,
  localparam int unsigned SEL_W = $clog2(DATA_W / BPP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  phase_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [BPP-1:0]    top_o
);
  logic [DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] shifted;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_shift
      if (i < BPP) begin : g_fill
        assign shifted[i] = 1'b0;
      end else begin : g_move
        assign shifted[i] = byte_q[i-BPP];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                byte_q <= '0;
    else if (pf_is_load(phase_i)) byte_q <= rdata_i;
    else                        byte_q <= shifted;
  end

  assign top_o = byte_q[DATA_W-1 -: BPP];

  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&phase_i) |=> byte_q == $past(rdata_i)); // R5
  AST_SHIFT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&phase_i) |=> byte_q[DATA_W-1:BPP] == $past(byte_q[DATA_W-BPP-1:0]) && byte_q[BPP-1:0] == '0); // R6
endmodule

// File: rtl/pf_fetch_top.sv
module pf_fetch_top
  import pf_pkg::*;
#(
  parameter int unsigned PIX_W      = 10,
  parameter int unsigned LINE_W     = 10,
  parameter int unsigned PAGE_BITS  = 9,
  parameter int unsigned LINE_PIXELS = 256,
  parameter int unsigned DATA_W     = PF_DATA_W,
  parameter int unsigned BPP        = PF_BPP,
  localparam int unsigned PPB       = DATA_W / BPP,
  localparam int unsigned SEL_W     = $clog2(PPB),
  localparam int unsigned BYTE_W    = $clog2(LINE_PIXELS / PPB),
  localparam int unsigned ADDR_W    = PAGE_BITS + BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_cnt_i,
  input  logic [LINE_W-1:0] line_cnt_i,
  input  logic              blank_q_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [BPP-1:0]    pixel_o
);
  logic [BPP-1:0] cur_pix;

  pf_addr_gen #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .PAGE_BITS(PAGE_BITS),
    .SEL_W(SEL_W), .BYTE_W(BYTE_W)
  ) u_addr (
    .pix_cnt_i (pix_cnt_i),
    .line_cnt_i(line_cnt_i),
    .addr_o    (mem_addr_o)
  );

  pf_mem_ctrl #(.GATE_OE(1'b1)) u_ctrl (
    .blank_q_i(blank_q_i),
    .ce_no    (mem_ce_no),
    .we_no    (mem_we_no),
    .oe_no    (mem_oe_no)
  );

  pf_shift_reg #(.DATA_W(DATA_W), .BPP(BPP)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(pix_cnt_i[SEL_W-1:0]),
    .rdata_i(mem_rdata_i),
    .top_o  (cur_pix)
  );

  assign pixel_o = blank_q_i ? '0 : cur_pix;

  AST_OE_OFF_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_q_i |-> mem_oe_no); // R3
  AST_BLANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_q_i |-> pixel_o == '0); // R7
  AST_ADDR_IGNORES_SPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(line_cnt_i[PAGE_BITS-1:0]) && $stable(pix_cnt_i[SEL_W+BYTE_W-1:SEL_W]))
      |-> $stable(mem_addr_o)); // R8
  AST_CTRL_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no && mem_we_no |=> !mem_ce_no && mem_we_no); // R2
endmodule

// File: tb/pf_fetch_top_test.sv
`timescale 1ns/1ps
module pf_fetch_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] pix = '0;
  logic [9:0] line = '0;
  logic       blank = 1'b1;
  logic [7:0] rdata;
  logic [14:0] addr;
  logic       ce_n, we_n, oe_n;
  logic [1:0] pixel;

  int n_chk = 0;
  int n_bad = 0;
  int model_reg = 0;
  bit last_load = 0;

  always #5 clk = ~clk;

  function automatic int mem_fn(input int a);
    return ((a * 37) ^ (a >> 5) ^ 8'h6C) & 8'hFF;
  endfunction

  assign rdata = oe_n ? 8'hFF : 8'(mem_fn(int'(addr)));

  pf_fetch_top uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_cnt_i(pix), .line_cnt_i(line),
    .blank_q_i(blank), .mem_rdata_i(rdata), .mem_addr_o(addr),
    .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n), .pixel_o(pixel)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(input int pc, input int lc, input bit bl);
    int exp_addr = ((lc % 512) * 64) + ((pc / 4) % 64);
    chk((lc > 511 || pc > 255 || pc % 4 != 0) ? "R8" : "R1", int'(addr), exp_addr);
    chk("R2", {ce_n, we_n}, 2'b01);
    chk("R3", int'(oe_n), int'(bl));
    if (bl) chk("R7", int'(pixel), 0);
    else chk(last_load ? "R5" : "R6", int'(pixel), (model_reg >> 6) & 3);
  endtask

  task automatic step(input int pc, input int lc, input bit bl);
    int exp_addr;
    @(negedge clk);
    pix = 10'(pc); line = 10'(lc); blank = bl;
    #1 compare(pc, lc, bl);
    exp_addr = ((lc % 512) * 64) + ((pc / 4) % 64);
    @(posedge clk);
    if (pc % 4 == 3) begin
      model_reg = bl ? 8'hFF : mem_fn(exp_addr);
      last_load = 1;
    end else begin
      model_reg = (model_reg << 2) & 8'hFF;
      last_load = 0;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3;
    chk("R4", int'(pixel), 0);
    chk("R2", {ce_n, we_n}, 2'b01);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    model_reg = 0;

    // sequential lines, visible and horizontal blank
    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 264; p++)
        step(p, l, p >= 256);

    // high line numbers: page wraps, bit 9 ignored
    for (int l = 510; l < 514; l++)
      for (int p = 0; p < 40; p++)
        step(p, l + 300, 1'b0);

    // blank toggled mid-byte, register keeps shifting
    for (int p = 0; p < 64; p++)
      step(p, 7, (p % 8) == 5 || (p % 8) == 6);

    // arbitrary counters
    for (int k = 0; k < 1500; k++)
      step(int'($urandom_range(1023, 0)), int'($urandom_range(1023, 0)), $urandom_range(3, 0) == 0);

    // asynchronous reset between edges
    for (int p = 0; p < 6; p++) step(p, 20, 1'b0);
    @(negedge clk);
    pix = 10'd5; blank = 1'b0;
    #2 rst_n = 1'b0;
    #1 chk("R4", int'(pixel), 0);
    model_reg = 0; last_load = 0;
    @(negedge clk) rst_n = 1'b1;
    for (int p = 0; p < 12; p++) step(p, 21, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule